// File: doc/BRIEF.md
# Parallel Matrix Deadlock Detector

This block decides whether a set of processes and resources has reached a deadlock. Software describes the resource-allocation graph cell by cell in a matrix whose rows stand for resources and whose columns stand for processes. Each cell says whether there is no edge, a request edge (the process waits for the resource) or a grant edge (the resource is held by the process). A start pulse then launches detection.

Detection works on a private working copy of the matrix. On every cycle it finds each row and column whose edges are all of one kind and clears every edge in those rows and columns, for the whole matrix at once. Such edges can never be part of a cycle. When a cycle clears nothing, the unit stops, raises done, and flags deadlock if any edge is left. The specific cycle is not identified. Because the programmed matrix is not touched, the same graph can be checked again after a few cell edits.

Top module: `deadlock_matrix`

## Requirements
- R1: After reset, busy, done and deadlock are 0 and every cell reads back as 00.
- R2: While busy is 0, a cycle with wr_en high stores wr_cell into the cell at (wr_row, wr_col). Bit 0 of a cell means request and bit 1 means grant, so 00 is no edge, 01 a request and 10 a grant. rd_cell shows the cell at (rd_row, rd_col) in the same cycle.
- R3: A start pulse taken while busy is 0 sets busy and clears done and deadlock on the same clock edge.
- R4: Each detection step clears, in parallel, all edges that lie in any row or column whose edges are all requests or all grants.
- R5: The first step that clears nothing ends detection. On that edge busy falls and done rises, so done rises s+1 clock edges after the start edge, where s is the number of steps that cleared something.
- R6: deadlock is 1 exactly when edges remain at the end. It is valid with done, and both hold until the next accepted start.
- R7: Cell writes presented while busy is 1 are ignored.
- R8: A start pulse while busy is 1 is ignored and does not change when done rises.
- R9: Detection leaves the programmed matrix unchanged, so a second start on the same cells gives the same result and timing.
- R10: The number of clearing steps in one run never exceeds NRES*NPROC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Cell write strobe |
| wr_row | input | RW | Resource index of the write |
| wr_col | input | PW | Process index of the write |
| wr_cell | input | 2 | Cell code to write |
| rd_row | input | RW | Resource index of the readback |
| rd_col | input | PW | Process index of the readback |
| rd_cell | output | 2 | Cell code at the readback address |
| start | input | 1 | Launch detection |
| busy | output | 1 | Detection in progress |
| done | output | 1 | Detection finished |
| deadlock | output | 1 | Edges remained at the end |

## Verification
Readback of a cell is combinational, so it is sampled half a cycle after the write edge. The result is due s+1 edges after the start edge, where s is the number of clearing steps. The bench works s out by hand for each graph and stores the due cycle next to the expected flag in its scoreboard. The monitor compares the flag on the cycle done rises and checks that this is the due cycle. Because of this, a start or write injected during a run shows up as a changed due cycle or a changed readback.

// File: rtl/deadlock_matrix.sv
module deadlock_matrix #(
  parameter int NRES  = 5,
  parameter int NPROC = 5,
  parameter int RW = (NRES  > 1) ? $clog2(NRES)  : 1,
  parameter int PW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_row,
  input  logic [PW-1:0] wr_col,
  input  logic [1:0]    wr_cell,
  input  logic [RW-1:0] rd_row,
  input  logic [PW-1:0] rd_col,
  output logic [1:0]    rd_cell,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          deadlock
);
  localparam int NCELL = NRES * NPROC;
  localparam int SW    = $clog2(NCELL + 1);

  logic [NRES-1:0][NPROC-1:0] req_m, gnt_m, req_w, gnt_w, kill;
  logic [NRES-1:0]  row_term;
  logic [NPROC-1:0] col_term;
  logic [SW-1:0]    steps;
  logic             any_kill;

  always_comb begin
    for (int r = 0; r < NRES; r++)
      row_term[r] = !((|req_w[r]) && (|gnt_w[r]));
    for (int c = 0; c < NPROC; c++) begin
      logic cr, cg;
      cr = 1'b0;
      cg = 1'b0;
      for (int r = 0; r < NRES; r++) begin
        cr = cr | req_w[r][c];
        cg = cg | gnt_w[r][c];
      end
      col_term[c] = !(cr && cg);
    end
    for (int r = 0; r < NRES; r++)
      for (int c = 0; c < NPROC; c++)
        kill[r][c] = (row_term[r] || col_term[c]) && (req_w[r][c] || gnt_w[r][c]);
  end

  assign any_kill = |kill;
  assign rd_cell  = (int'(rd_row) < NRES && int'(rd_col) < NPROC)
                  ? {gnt_m[rd_row][rd_col], req_m[rd_row][rd_col]} : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_m <= '0;
      gnt_m <= '0;
    end else if (wr_en && !busy && int'(wr_row) < NRES && int'(wr_col) < NPROC) begin
      req_m[wr_row][wr_col] <= wr_cell[0];
      gnt_m[wr_row][wr_col] <= wr_cell[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_w    <= '0;
      gnt_w    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      deadlock <= 1'b0;
      steps    <= '0;
    end else if (!busy) begin
      if (start) begin
        req_w    <= req_m;
        gnt_w    <= gnt_m;
        busy     <= 1'b1;
        done     <= 1'b0;
        deadlock <= 1'b0;
        steps    <= '0;
      end
    end else if (any_kill) begin
      req_w <= req_w & ~kill;
      gnt_w <= gnt_w & ~kill;
      steps <= steps + 1'b1;
    end else begin
      busy     <= 1'b0;
      done     <= 1'b1;
      deadlock <= (|req_w) || (|gnt_w);
    end
  end

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R5
  AST_DEADLOCK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |-> done); // R6
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(req_m) && $stable(gnt_m))); // R7
  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> ((req_w & ~$past(req_w)) == '0) && ((gnt_w & ~$past(gnt_w)) == '0)); // R4
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(steps) <= NCELL); // R10
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done); // R3
endmodule

// File: tb/test_deadlock_matrix.sv
module test_deadlock_matrix;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0;
  logic [2:0] wr_row = 0, rd_row = 0;
  logic [2:0] wr_col = 0, rd_col = 0;
  logic [1:0] wr_cell = 0;
  logic [1:0] rd_cell;
  logic busy, done, deadlock;

  deadlock_matrix i_deadlock_matrix (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_cell(wr_cell), .rd_row(rd_row), .rd_col(rd_col), .rd_cell(rd_cell),
    .start(start), .busy(busy), .done(done), .deadlock(deadlock));

  always #10 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic q_dl[$];
  int   q_due[$];
  string q_tag[$];
  logic done_q = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done && !done_q) begin
      if (q_dl.size() == 0) check(0, "R5 unexpected done", 1, 0);
      else begin
        logic e_dl; int e_due; string t;
        e_dl = q_dl.pop_front(); e_due = q_due.pop_front(); t = q_tag.pop_front();
        check(deadlock == e_dl, {t, " deadlock (R6)"}, deadlock, e_dl);
        check(cyc == e_due, {t, " done cycle (R5)"}, cyc, e_due);
      end
    end
    done_q <= done;
  end

  task automatic wr(input int r, input int c, input logic [1:0] d);
    @(negedge clk);
    wr_en = 1; wr_row = 3'(r); wr_col = 3'(c); wr_cell = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic clear_all();
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 5; c++) wr(r, c, 2'b00);
  endtask

  task automatic run(input logic dl, input int s, input string tag);
    @(negedge clk);
    start = 1;
    q_dl.push_back(dl); q_due.push_back(cyc + s + 2); q_tag.push_back(tag);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ring5();
    clear_all();
    for (int i = 0; i < 5; i++) begin
      wr(i, i, 2'b10);
      wr((i + 1) % 5, i, 2'b01);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !deadlock, "R1 flags", {busy, done, deadlock}, 0);
    rd_row = 2; rd_col = 3; #1;
    check(rd_cell == 2'b00, "R1 cell", rd_cell, 0);
    rst_n = 1;

    // R2: write and readback
    wr(3, 4, 2'b10);
    rd_row = 3; rd_col = 4; #1;
    check(rd_cell == 2'b10, "R2 readback grant", rd_cell, 2);
    wr(3, 4, 2'b01); #1;
    check(rd_cell == 2'b01, "R2 readback request", rd_cell, 1);
    wr(3, 4, 2'b00);

    // R3/R5: empty graph, zero steps
    run(0, 0, "R5 empty");
    check(busy && !done, "R3 busy after start", {busy, done}, 2);
    wait_done();

    // two-process cycle: nothing removable
    wr(0, 0, 2'b10); wr(1, 0, 2'b01); wr(1, 1, 2'b10); wr(0, 1, 2'b01);
    run(1, 0, "R6 two-cycle");
    wait_done();

    // R4: cycle plus a hanging request, one step
    wr(0, 2, 2'b01);
    run(1, 1, "R4 cycle with tail");
    wait_done();

    // R4: chain without cycle, two steps
    clear_all();
    wr(0, 0, 2'b10); wr(1, 0, 2'b01); wr(1, 1, 2'b10);
    run(0, 2, "R4 chain");
    wait_done();
    // R9: rerun gives same answer, matrix intact
    run(0, 2, "R9 rerun chain");
    wait_done();
    rd_row = 1; rd_col = 0; #1;
    check(rd_cell == 2'b01, "R9 matrix kept", rd_cell, 1);

    // full five-way ring
    ring5();
    run(1, 0, "R6 ring5");
    wait_done();

    // broken ring: five steps; inject write and start while busy
    wr(0, 4, 2'b00);
    run(0, 5, "R8 broken ring");
    @(negedge clk);
    start = 1;                                  // R8 ignored
    wr_en = 1; wr_row = 3'd2; wr_col = 3'd2; wr_cell = 2'b00;  // R7 ignored
    @(negedge clk);
    start = 0; wr_en = 0;
    wait_done();
    rd_row = 2; rd_col = 2; #1;
    check(rd_cell == 2'b10, "R7 write while busy", rd_cell, 2);
    run(0, 5, "R7 rerun broken ring");
    wait_done();

    // R1: reset clears the matrix
    ring5();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    done_q = 0;
    rd_row = 1; rd_col = 0; #1;
    check(rd_cell == 2'b00 && !done, "R1 reset clears", rd_cell, 0);
    run(0, 0, "R1 after reset");
    wait_done();
    check(q_dl.size() == 0, "R5 pending results", q_dl.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule